// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block tracks up to 62 interrupt levels. Fourteen internal levels are always present. Up to four external groups of twelve levels each can be added. Each level holds one of four states (disarmed, armed, waiting, active) and its own enable flag.

Hardware trigger pulses move armed levels to waiting. At a safe-point strobe from a running processor, the highest-priority eligible level is made active, and the block reports it one cycle later as a take request carrying the level number.

Groups are masked by inhibit inputs taken from the processor status word. An inhibited group drops out of the priority scan, but an active level anywhere still holds off every level below it. Software reaches any level through a command port. A write names a group code and a bit mask of levels within that group, and applies an arm, disarm, enable, disable or trigger operation. A read returns one of three per-level status views for one group.

Top module: `prio_irq_ctl`

## Requirements
- R1: After reset every level is disarmed and disabled, take_o is 0 and rd_data_o is 0.
- R2: A hw_trig_i pulse moves an armed level to waiting. A pulse on a disarmed level leaves it disarmed.
- R3: A write (cmd_valid_i=1, cmd_wr_i=1) uses group code cmd_addr_i[31:28] and operation cmd_addr_i[10:8]. The operations are 1 arm, 2 disarm, 3 enable and 4 disable. The operation acts on every level whose bit is set in cmd_data_i. For group 0 the bits are [13:0], and internal level k uses bit k. For groups 2 to 5 the bits are [11:0], and level k of group g has global index 14+12*(g-2)+k. Arm and disarm leave active levels untouched.
- R4: Write operation 5 puts each selected level straight into the active state, whatever its prior state.
- R5: A read (cmd_valid_i=1, cmd_wr_i=0) sets rd_data_o on the next cycle. cmd_addr_i[10:8] selects the view: 0 is armed-or-waiting, 1 is waiting-or-active, 2 is enabled. Bit k of rd_data_o belongs to level k of the addressed group.
- R6: Group codes other than 0, 2, 3, 4 and 5 select nothing. Writes to them change no level, and reads from them return 0.
- R7: A level is taken in a cycle where safe_i=1, run_i=1 and no write is presented. The level taken is the lowest-index level that is waiting, enabled and not inhibited, provided no lower-index level is active. It becomes active, and on the next cycle take_o=1 with take_lvl_o giving its global index.
- R8: An active level blocks every higher-index level from being taken, even while the active level's own group is inhibited.
- R9: ci_i inhibits levels 6 to 9, ii_i inhibits levels 10 to 13, and ei_i inhibits levels 14 to 61. An inhibited waiting level is never taken and does not block higher-index levels.
- R10: fault_i=1 inhibits levels 2, 3 and 4.
- R11: clr_valid_i=1 with clr_lvl_i naming an active level returns that level to armed.
- R12: When a write command selects a level in the same cycle as a hardware trigger, the command's result prevails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| safe_i | input | 1 | Safe-point strobe |
| run_i | input | 1 | Processor in run or wait condition |
| ci_i | input | 1 | Counter group inhibit |
| ii_i | input | 1 | I/O group inhibit |
| ei_i | input | 1 | External groups inhibit |
| fault_i | input | 1 | Fault-detected flag |
| hw_trig_i | input | 62 | Hardware trigger pulse per level |
| clr_valid_i | input | 1 | Clear-active request |
| clr_lvl_i | input | 6 | Level to clear |
| cmd_valid_i | input | 1 | Command present |
| cmd_wr_i | input | 1 | 1 write, 0 read |
| cmd_addr_i | input | 32 | Group code [31:28], operation or view [10:8] |
| cmd_data_i | input | 32 | Level selection mask |
| rd_data_o | output | 16 | Read result |
| take_o | output | 1 | Take-interrupt request |
| take_lvl_o | output | 6 | Level taken |

## Verification
A level's state changes on the edge that samples its trigger, command or clear. A read issued on the following cycle therefore returns the new status one cycle after that read. take_o and take_lvl_o appear one cycle after the strobe cycle. The bench drives inputs on falling edges and keeps a behavioural model that advances on the same rising edge as the design. It compares take_o, take_lvl_o and rd_data_o at every falling edge. Its hand-computed checks sample exactly one cycle after each strobe or read.

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl #(
  parameter int N_INT = 14,
  parameter int GRP_N = 12,
  parameter logic [3:0] EXT_MASK = 4'b1111,
  parameter int CZ_LO = 6,
  parameter int CZ_HI = 9,
  parameter int IO_LO = 10,
  parameter int IO_HI = 13,
  parameter int FL_LO = 2,
  parameter int FL_HI = 4,
  localparam int L = N_INT + 4 * GRP_N,
  localparam int IW = $clog2(L)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          safe_i,
  input  logic          run_i,
  input  logic          ci_i,
  input  logic          ii_i,
  input  logic          ei_i,
  input  logic          fault_i,
  input  logic [L-1:0]  hw_trig_i,
  input  logic          clr_valid_i,
  input  logic [IW-1:0] clr_lvl_i,
  input  logic          cmd_valid_i,
  input  logic          cmd_wr_i,
  input  logic [31:0]   cmd_addr_i,
  input  logic [31:0]   cmd_data_i,
  output logic [15:0]   rd_data_o,
  output logic          take_o,
  output logic [IW-1:0] take_lvl_o
);
  typedef enum logic [1:0] {S_DIS, S_ARM, S_WAIT, S_ACT} lvl_st_t;

  function automatic int gc_of(int i);
    return (i < N_INT) ? 0 : 2 + (i - N_INT) / GRP_N;
  endfunction
  function automatic int pos_of(int i);
    return (i < N_INT) ? i : (i - N_INT) % GRP_N;
  endfunction
  function automatic bit pres_of(int i);
    if (i < N_INT) return 1'b1;
    return EXT_MASK[(i - N_INT) / GRP_N];
  endfunction

  wire [3:0] gc = cmd_addr_i[31:28];
  wire [2:0] op = cmd_addr_i[10:8];
  wire wr = cmd_valid_i & cmd_wr_i;
  wire rd = cmd_valid_i & ~cmd_wr_i;
  wire gc_ok = (gc == 4'd0) || (gc >= 4'd2 && gc <= 4'd5);

  logic [L-1:0] act_v, wt_v, arm_v, en_v, inh_v;
  logic [IW-1:0] win;
  logic have, take_go;
  logic [15:0] rd_n;

  always_comb begin
    logic stop;
    stop = 1'b0;
    win = '0;
    have = 1'b0;
    for (int i = 0; i < L; i++) begin
      if (!stop) begin
        if (act_v[i]) stop = 1'b1;
        else if (wt_v[i] && en_v[i] && !inh_v[i]) begin
          win = IW'(i);
          have = 1'b1;
          stop = 1'b1;
        end
      end
    end
  end

  assign take_go = safe_i & run_i & have & ~wr;

  for (genvar i = 0; i < L; i++) begin : g_lvl
    localparam int GC = gc_of(i);
    localparam int POS = pos_of(i);
    localparam bit PR = pres_of(i);
    localparam bit IN_CZ = (i >= CZ_LO) && (i <= CZ_HI);
    localparam bit IN_IO = (i >= IO_LO) && (i <= IO_HI);
    localparam bit IN_EX = (i >= N_INT);
    localparam bit IN_FL = (i >= FL_LO) && (i <= FL_HI);

    lvl_st_t s, nx;
    logic e, ne;
    wire sel = PR && wr && (gc == 4'(GC)) && cmd_data_i[POS];

    always_comb begin
      nx = s;
      ne = e;
      if (hw_trig_i[i] && s == S_ARM) nx = S_WAIT;
      if (take_go && win == IW'(i)) nx = S_ACT;
      if (clr_valid_i && clr_lvl_i == IW'(i) && s == S_ACT) nx = S_ARM;
      if (sel) begin
        case (op)
          3'd1: if (s != S_ACT) nx = S_ARM;
          3'd2: if (s != S_ACT) nx = S_DIS;
          3'd3: ne = 1'b1;
          3'd4: ne = 1'b0;
          3'd5: nx = S_ACT;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s <= S_DIS;
        e <= 1'b0;
      end else begin
        s <= nx;
        e <= ne;
      end
    end

    assign act_v[i] = (s == S_ACT);
    assign wt_v[i]  = (s == S_WAIT);
    assign arm_v[i] = (s == S_ARM);
    assign en_v[i]  = e;
    assign inh_v[i] = (IN_CZ & ci_i) | (IN_IO & ii_i) | (IN_EX & ei_i) | (IN_FL & fault_i);

    p_dis_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (s == S_DIS && !sel) |=> s == S_DIS);
    p_trig_act_r4: assert property (@(posedge clk) disable iff (rst)
      (sel && op == 3'd5) |=> s == S_ACT);
    p_clr_arm_r11: assert property (@(posedge clk) disable iff (rst)
      (clr_valid_i && clr_lvl_i == IW'(i) && s == S_ACT && !sel) |=> s == S_ARM);
  end

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < L; i++) begin
      if (pres_of(i) && gc == 4'(gc_of(i))) begin
        case (op)
          3'd0: rd_n[4'(pos_of(i))] = arm_v[i] | wt_v[i];
          3'd1: rd_n[4'(pos_of(i))] = wt_v[i] | act_v[i];
          3'd2: rd_n[4'(pos_of(i))] = en_v[i];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      take_lvl_o <= '0;
      rd_data_o <= '0;
    end else begin
      take_o <= take_go;
      if (take_go) take_lvl_o <= win;
      if (rd) rd_data_o <= rd_n;
    end
  end

  p_take_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(safe_i && run_i && !wr));
  p_take_active_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> act_v[take_lvl_o]);
  p_take_uninh_r9: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((($past(inh_v) >> take_lvl_o) & L'(1)) == '0));
  p_bad_group_r6: assert property (@(posedge clk) disable iff (rst)
    (rd && !gc_ok) |=> rd_data_o == '0);
endmodule

// File: tb/sim_prio_irq_ctl.sv
module sim_prio_irq_ctl;
  localparam int L = 62;
  logic clk = 0, rst = 1;
  logic safe_i = 0, run_i = 1, ci_i = 0, ii_i = 0, ei_i = 0, fault_i = 0;
  logic [L-1:0] hw_trig_i = '0;
  logic clr_valid_i = 0;
  logic [5:0] clr_lvl_i = '0;
  logic cmd_valid_i = 0, cmd_wr_i = 0;
  logic [31:0] cmd_addr_i = '0, cmd_data_i = '0;
  logic [15:0] rd_data_o;
  logic take_o;
  logic [5:0] take_lvl_o;

  prio_irq_ctl u0 (.*);

  always #5 clk = ~clk;

  int nchk = 0, nbad = 0;
  bit live = 0;
  string tag = "R1";

  int mst[L], men[L];
  int mtake = 0, mlvl = 0, mrd = 0;
  int w, nst, nen, lv;
  bit blk, go;

  function automatic bit m_inh(int i);
    return (i >= 6 && i <= 9 && ci_i) || (i >= 10 && i <= 13 && ii_i) ||
           (i >= 14 && ei_i) || (i >= 2 && i <= 4 && fault_i);
  endfunction
  function automatic int lvl_of(int g, int k);
    if (g == 0) return (k < 14) ? k : -1;
    if (g >= 2 && g <= 5) return (k < 12) ? 14 + 12 * (g - 2) + k : -1;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < L; i++) begin mst[i] = 0; men[i] = 0; end
      mtake = 0; mlvl = 0; mrd = 0;
    end else begin
      w = -1; blk = 0;
      for (int i = 0; i < L; i++)
        if (!blk) begin
          if (mst[i] == 3) blk = 1;
          else if (mst[i] == 2 && men[i] != 0 && !m_inh(i)) begin w = i; blk = 1; end
        end
      go = safe_i && run_i && w >= 0 && !(cmd_valid_i && cmd_wr_i);
      if (cmd_valid_i && !cmd_wr_i) begin
        mrd = 0;
        for (int k = 0; k < 16; k++) begin
          lv = lvl_of(int'(cmd_addr_i[31:28]), k);
          if (lv >= 0) case (cmd_addr_i[10:8])
            3'd0: if (mst[lv] == 1 || mst[lv] == 2) mrd |= (1 << k);
            3'd1: if (mst[lv] >= 2) mrd |= (1 << k);
            3'd2: if (men[lv] != 0) mrd |= (1 << k);
            default: ;
          endcase
        end
      end
      for (int i = 0; i < L; i++) begin
        nst = mst[i]; nen = men[i];
        if (hw_trig_i[i] && mst[i] == 1) nst = 2;
        if (go && w == i) nst = 3;
        if (clr_valid_i && int'(clr_lvl_i) == i && mst[i] == 3) nst = 1;
        if (cmd_valid_i && cmd_wr_i)
          for (int k = 0; k < 16; k++)
            if (cmd_data_i[k] && lvl_of(int'(cmd_addr_i[31:28]), k) == i)
              case (cmd_addr_i[10:8])
                3'd1: if (mst[i] != 3) nst = 1;
                3'd2: if (mst[i] != 3) nst = 0;
                3'd3: nen = 1;
                3'd4: nen = 0;
                3'd5: nst = 3;
                default: ;
              endcase
        mst[i] = nst; men[i] = nen;
      end
      mtake = go ? 1 : 0;
      if (go) mlvl = w;
    end
  end

  task automatic chk(bit ok, string t, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk(take_o === mtake[0], {tag, " take_o vs model"}, int'(take_o), mtake);
    if (mtake != 0) chk(int'(take_lvl_o) == mlvl, {tag, " take_lvl_o vs model"}, int'(take_lvl_o), mlvl);
    chk(int'(rd_data_o) == mrd, {tag, " rd_data_o vs model"}, int'(rd_data_o), mrd);
  end

  task automatic wcmd(input int g, input int o, input int d);
    @(negedge clk);
    cmd_valid_i = 1; cmd_wr_i = 1;
    cmd_addr_i = {4'(g), 17'd0, 3'(o), 8'd0}; cmd_data_i = 32'(d);
    @(negedge clk);
    cmd_valid_i = 0; cmd_wr_i = 0;
  endtask
  task automatic rdcmd(input int g, input int v);
    @(negedge clk);
    cmd_valid_i = 1; cmd_wr_i = 0;
    cmd_addr_i = {4'(g), 17'd0, 3'(v), 8'd0}; cmd_data_i = '0;
    @(negedge clk);
    cmd_valid_i = 0;
  endtask
  task automatic rdhand(input int g, input int v, input int mask, input int exp, input string t);
    rdcmd(g, v);
    chk((int'(rd_data_o) & mask) == exp, t, int'(rd_data_o) & mask, exp);
  endtask
  task automatic hw(input int lvl);
    @(negedge clk); hw_trig_i[lvl] = 1;
    @(negedge clk); hw_trig_i = '0;
  endtask
  task automatic clr(input int lvl);
    @(negedge clk); clr_valid_i = 1; clr_lvl_i = 6'(lvl);
    @(negedge clk); clr_valid_i = 0;
  endtask
  task automatic strobe(input int exp, input string t);
    @(negedge clk); safe_i = 1;
    @(negedge clk); safe_i = 0;
    chk(take_o === (exp >= 0), {t, " take_o"}, int'(take_o), exp >= 0);
    if (exp >= 0) chk(int'(take_lvl_o) == exp, {t, " take_lvl_o"}, int'(take_lvl_o), exp);
  endtask
  task automatic armen(input int g, input int d);
    wcmd(g, 1, d); wcmd(g, 3, d);
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(take_o === 1'b0, "R1 take_o after reset", int'(take_o), 0);
    chk(rd_data_o === 16'd0, "R1 rd_data_o after reset", int'(rd_data_o), 0);
    live = 1;
    rdhand(0, 0, 16'hffff, 0, "R1 no level armed");

    tag = "R3";
    wcmd(0, 1, 16'h1021);
    rdhand(0, 0, 16'hffff, 16'h1021, "R3 arm mask");
    wcmd(0, 3, 16'h0021);
    tag = "R5";
    rdhand(0, 2, 16'hffff, 16'h0021, "R5 enabled view");

    tag = "R2";
    @(negedge clk); hw_trig_i[5] = 1; hw_trig_i[3] = 1;
    @(negedge clk); hw_trig_i = '0;
    rdhand(0, 1, 16'hffff, 16'h0020, "R2 armed level waits, disarmed ignored");
    rdhand(0, 0, 16'hffff, 16'h1021, "R5 armed-or-waiting view");

    tag = "R7";
    run_i = 0;
    strobe(-1, "R7 no take while not running");
    run_i = 1;
    strobe(5, "R7 take level 5");
    rdhand(0, 1, 16'hffff, 16'h0020, "R7 level 5 active");

    tag = "R8";
    hw(12); wcmd(0, 3, 16'h1000);
    strobe(-1, "R8 active 5 blocks 12");
    tag = "R11";
    clr(5);
    rdhand(0, 0, 16'h0020, 16'h0020, "R11 cleared level back to armed");
    tag = "R7";
    strobe(12, "R7 take level 12");

    tag = "R9";
    armen(0, 16'h0080); hw(7); ci_i = 1;
    strobe(-1, "R9 inhibited 7 not taken");
    ci_i = 0;
    strobe(7, "R9 take 7 when permitted");
    ci_i = 1;
    tag = "R8";
    armen(2, 16'h0001); hw(14);
    strobe(-1, "R8 active level in inhibited group blocks 14");
    clr(7); clr(12);
    strobe(14, "R8 take 14 after clears");
    clr(14);

    tag = "R9";
    armen(0, 16'h0100); hw(8);
    armen(3, 16'h0002); hw(27);
    strobe(27, "R9 inhibited waiting 8 does not block 27");
    clr(27);

    tag = "R10";
    fault_i = 1;
    armen(0, 16'h0004); hw(2);
    armen(2, 16'h0040); hw(20);
    strobe(20, "R10 fault masks level 2");
    fault_i = 0;
    strobe(2, "R10 level 2 taken once fault clears");

    tag = "R4";
    wcmd(5, 5, 16'h0800);
    rdhand(5, 1, 16'hffff, 16'h0800, "R4 trigger command activates disarmed level");

    tag = "R6";
    wcmd(1, 1, 16'hffff);
    rdhand(1, 0, 16'hffff, 0, "R6 group 1 reads zero");
    rdhand(6, 2, 16'hffff, 0, "R6 group 6 reads zero");
    rdhand(0, 0, 16'h0008, 0, "R6 group 1 write left level 3 disarmed");

    tag = "R12";
    wcmd(0, 1, 16'h0200);
    @(negedge clk);
    hw_trig_i[9] = 1;
    cmd_valid_i = 1; cmd_wr_i = 1;
    cmd_addr_i = {4'd0, 17'd0, 3'd2, 8'd0}; cmd_data_i = 32'h200;
    @(negedge clk);
    hw_trig_i = '0; cmd_valid_i = 0; cmd_wr_i = 0;
    rdhand(0, 0, 16'h0200, 0, "R12 disarm wins over trigger");
    rdhand(0, 1, 16'h0200, 0, "R12 level 9 not waiting");

    tag = "R3";
    wcmd(0, 4, 16'h0001);
    rdhand(0, 2, 16'h0001, 0, "R3 disable clears enable");
    wcmd(0, 2, 16'h0004);
    rdhand(0, 1, 16'h0004, 16'h0004, "R3 disarm leaves active level 2");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule